// File: doc/BRIEF.md
# GPIO Wake Event Detector

The detector watches a bank of sixteen general-purpose input pins and turns qualifying activity on them into wake-up and interrupt requests. Each pin first passes through a two-stage synchronizer and its own debounce filter. The filter is timed by a slow tick that the caller supplies. The filtered level is then made active-high or active-low as programmed. It is qualified either as a transition into the active state or as a held active level.

Edge-qualified events set sticky status bits that software clears by writing ones. Level-qualified events show in the status for as long as the active level lasts. Three registered outputs each form the OR of the enabled status bits that pass their own routing mask: an interrupt request, a system-management interrupt and a system-control interrupt. All control and status access goes through a plain single-cycle register port, with a write strobe, an address, write data and combinational read data.

Top module: `gpio_wake_detect`

## Requirements
- R1: After a synchronous active-low reset, every control register and every status bit reads 0, and `irq_o`, `smi_o` and `sci_o` are low.
- R2: The register offsets are as follows. Offset 0 is enable. Offset 1 is invert, where 1 selects active-low. Offset 2 is mode, where 1 selects level and 0 selects edge. Offset 3 is debounce, holding a 2-bit code per input in bits [2i+1:2i]. Offset 4 is status. Offsets 5, 6 and 7 are the routing masks for `irq_o`, `smi_o` and `sci_o`. The 16-bit registers read back what was written, with bits above 15 reading 0. Offsets 8 to 15 read 0.
- R3: In edge mode, an enabled input whose qualified level goes from inactive to active sets its status bit. The bit stays set after the input returns to inactive.
- R4: With invert set, a low pin level is active, so a falling pin edge sets the status in edge mode.
- R5: In level mode, an enabled input's status bit reads 1 while its qualified level is active and 0 once it is inactive, with nothing latched.
- R6: Writing 1 to a status bit at offset 4 clears its sticky part, and writing 0 leaves it unchanged. A new edge in the same cycle as the clear wins over the clear.
- R7: An input whose enable bit is 0 never shows in status and never drives any output.
- R8: The debounce codes 0, 1, 2 and 3 require 0, 2, 8 and 32 slow ticks respectively. A new synchronized level is accepted only after it has differed from the filtered level for that many consecutive ticks. Shorter pulses are discarded. Code 0 passes the synchronized level on the next clock.
- R9: Each of `irq_o`, `smi_o` and `sci_o` is a register holding the OR of status ANDed with that output's routing mask. It follows status with one clock of latency.
- R10: Each input's enable, invert, mode and debounce settings act on that input only. Activity on other, disabled inputs does not disturb its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-clock pulse that times the debounce counters |
| pins_i | input | 16 | Raw, possibly asynchronous, input pins |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset for read and write |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |
| irq_o | output | 1 | Routed interrupt request |
| smi_o | output | 1 | Routed system-management interrupt |
| sci_o | output | 1 | Routed system-control interrupt |

## Verification
The assertions take `slow_tick` to be a single-clock pulse and treat the pins as asynchronous. They make no assumption about pin timing beyond what the synchronizer absorbs. They also expect each status clear to be a single-cycle write, so that sticky bits are observed over exactly one edge. The stimulus changes pins and register inputs only on falling clock edges. It sweeps every input through both polarities and both modes, holding each pin for many clocks. In the debounce cases, pulse lengths sit well clear of the thresholds of 2, 8 and 32 ticks, so the expected outcome does not depend on where the tick falls.

// File: rtl/gwd_pkg.sv
// Package gwd_pkg: register offsets and the debounce code decode shared by
// the register file and the per-pin filters of the GPIO wake detector.
package gwd_pkg;

    localparam logic [3:0] OFS_ENABLE = 4'd0;
    localparam logic [3:0] OFS_INVERT = 4'd1;
    localparam logic [3:0] OFS_MODE   = 4'd2;
    localparam logic [3:0] OFS_DEBNC  = 4'd3;
    localparam logic [3:0] OFS_STATUS = 4'd4;
    localparam logic [3:0] OFS_R_IRQ  = 4'd5;
    localparam logic [3:0] OFS_R_SMI  = 4'd6;
    localparam logic [3:0] OFS_R_SCI  = 4'd7;

    // Map a 2-bit debounce code onto its tick threshold.
    function automatic int debounce_ticks(input logic [1:0] code,
                                          input int t1, input int t2, input int t3);
        case (code)
            2'd0:    return 0;
            2'd1:    return t1;
            2'd2:    return t2;
            default: return t3;
        endcase
    endfunction

endpackage

// File: rtl/gwd_filter.sv
// Module gwd_filter: synchronizes one asynchronous pin into clk and debounces
// it. A new level is adopted only after it has differed from the filtered
// level for the selected number of consecutive slow ticks. Code 0 adopts it
// on the next clock. Assumes slow_tick is a one-clock pulse.
module gwd_filter #(
    parameter int T1 = 2,
    parameter int T2 = 8,
    parameter int T3 = 32,
    localparam int CW = $clog2(T3 + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       level_o
);
    import gwd_pkg::*;

    logic          sync1_q, sync2_q, filt_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Purpose: decode the selected threshold.
    always_comb limit = CW'(debounce_ticks(sel, T1, T2, T3));

    // Purpose: two-flop synchronizer for the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
        end
    end

    // Purpose: count consecutive ticks of disagreement and adopt the new level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            cnt_q  <= '0;
        end else if (sync2_q == filt_q) begin
            cnt_q <= '0;
        end else if (limit == '0) begin
            filt_q <= sync2_q;
            cnt_q  <= '0;
        end else if (slow_tick) begin
            if (cnt_q + CW'(1) >= limit) begin
                filt_q <= sync2_q;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign level_o = filt_q;

    // R8
    filt_takes_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> filt_q == $past(sync2_q));
    // R8
    filt_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(filt_q) && $past(limit) != '0) |-> $past(slow_tick));

endmodule

// File: rtl/gwd_detect.sv
// Module gwd_detect: applies polarity, qualifies each input as edge or level,
// and keeps the sticky write-1-to-clear status. pend_o is the enabled status
// seen by software and by the routing stage. Assumes clr_i is a one-cycle strobe.
module gwd_detect #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] inv_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] act, act_q, edge_set, sticky_q;

    // Purpose: polarity before detection, and edge qualification.
    always_comb begin
        act      = level_i ^ inv_i;
        edge_set = en_i & ~lvl_i & act & ~act_q;
    end

    // Purpose: remember the previous qualified level per input.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act;
    end

    // Purpose: sticky bits, where a new edge wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= (sticky_q & ~clr_i) | edge_set;
    end

    // Purpose: visible status, with level events live and everything gated by enable.
    always_comb pend_o = (sticky_q | (lvl_i & act)) & en_i;

    // R3
    sticky_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky_q & ~$past(sticky_q)) & ~$past(edge_set)) == '0);
    // R6
    clear_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q & $past(clr_i & ~edge_set) & $past(sticky_q)) == '0);

endmodule

// File: rtl/gwd_regs.sv
// Module gwd_regs: single-cycle register port for the detector configuration.
// Reads are combinational on addr. A write to the status offset produces a
// one-cycle clear strobe instead of storing data.
module gwd_regs #(
    parameter int N = 16,
    localparam int DW = 2 * N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [DW-1:0] wdata,
    input  logic [N-1:0]  pend_i,
    output logic [N-1:0]  en_o,
    output logic [N-1:0]  inv_o,
    output logic [N-1:0]  lvl_o,
    output logic [DW-1:0] db_o,
    output logic [N-1:0]  r_irq_o,
    output logic [N-1:0]  r_smi_o,
    output logic [N-1:0]  r_sci_o,
    output logic [N-1:0]  clr_o,
    output logic [DW-1:0] rdata
);
    import gwd_pkg::*;

    // Purpose: store configuration words on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            inv_o   <= '0;
            lvl_o   <= '0;
            db_o    <= '0;
            r_irq_o <= '0;
            r_smi_o <= '0;
            r_sci_o <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_ENABLE: en_o    <= wdata[N-1:0];
                OFS_INVERT: inv_o   <= wdata[N-1:0];
                OFS_MODE:   lvl_o   <= wdata[N-1:0];
                OFS_DEBNC:  db_o    <= wdata;
                OFS_R_IRQ:  r_irq_o <= wdata[N-1:0];
                OFS_R_SMI:  r_smi_o <= wdata[N-1:0];
                OFS_R_SCI:  r_sci_o <= wdata[N-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: write-1-to-clear strobe for the status bits.
    always_comb clr_o = (wr_en && addr == OFS_STATUS) ? wdata[N-1:0] : '0;

    // Purpose: read multiplexer, where unused offsets and upper bits read 0.
    always_comb begin
        case (addr)
            OFS_ENABLE: rdata = DW'(en_o);
            OFS_INVERT: rdata = DW'(inv_o);
            OFS_MODE:   rdata = DW'(lvl_o);
            OFS_DEBNC:  rdata = db_o;
            OFS_STATUS: rdata = DW'(pend_i);
            OFS_R_IRQ:  rdata = DW'(r_irq_o);
            OFS_R_SMI:  rdata = DW'(r_smi_o);
            OFS_R_SCI:  rdata = DW'(r_sci_o);
            default:    rdata = '0;
        endcase
    end

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_ENABLE) |=> en_o == $past(wdata[N-1:0]));

endmodule

// File: rtl/gwd_route.sv
// Module gwd_route: forms the three registered event outputs. Each output is
// the OR of the pending status masked by its own routing word.
module gwd_route #(
    parameter int N = 16,
    parameter int OUTS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0]             pend_i,
    input  logic [OUTS-1:0][N-1:0]   mask_i,
    output logic [OUTS-1:0]          out_o
);
    // Purpose: register the masked OR for every output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o <= '0;
        end else begin
            for (int k = 0; k < OUTS; k++) out_o[k] <= |(pend_i & mask_i[k]);
        end
    end

    // R9
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> (out_o == '0));

endmodule

// File: rtl/gpio_wake_detect.sv
// Module gpio_wake_detect: top of the GPIO wake event detector. It holds one
// filter per input, the shared detection and status stage, the register port
// and the routing of status onto the interrupt, system-management and
// system-control outputs. Assumes slow_tick is a one-clock pulse in clk.
module gpio_wake_detect #(
    parameter int N_IN = 16,
    parameter int DB_T1 = 2,
    parameter int DB_T2 = 8,
    parameter int DB_T3 = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  slow_tick,
    input  logic [N_IN-1:0]       pins_i,
    input  logic                  wr_en,
    input  logic [3:0]            addr,
    input  logic [2*N_IN-1:0]     wdata,
    output logic [2*N_IN-1:0]     rdata,
    output logic                  irq_o,
    output logic                  smi_o,
    output logic                  sci_o
);
    localparam int DW = 2 * N_IN;

    logic [N_IN-1:0] level, en, inv, lvl, clr, pend, r_irq, r_smi, r_sci;
    logic [DW-1:0]   db;
    logic [2:0][N_IN-1:0] masks;
    logic [2:0]      outs;

    // One synchronizer and debounce filter per input (R8, R10).
    for (genvar i = 0; i < N_IN; i++) begin : g_pin
        gwd_filter #(.T1(DB_T1), .T2(DB_T2), .T3(DB_T3)) u_filt (
            .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
            .pin(pins_i[i]), .sel(db[2*i +: 2]), .level_o(level[i])
        );
    end

    gwd_detect #(.N(N_IN)) u_detect (
        .clk(clk), .rst_n(rst_n), .level_i(level), .en_i(en), .inv_i(inv),
        .lvl_i(lvl), .clr_i(clr), .pend_o(pend)
    );

    gwd_regs #(.N(N_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .pend_i(pend), .en_o(en), .inv_o(inv), .lvl_o(lvl), .db_o(db),
        .r_irq_o(r_irq), .r_smi_o(r_smi), .r_sci_o(r_sci), .clr_o(clr),
        .rdata(rdata)
    );

    assign masks = {r_sci, r_smi, r_irq};

    gwd_route #(.N(N_IN), .OUTS(3)) u_route (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(masks), .out_o(outs)
    );

    assign irq_o = outs[0];
    assign smi_o = outs[1];
    assign sci_o = outs[2];

endmodule

// File: tb/gpio_wake_detect_bench.sv
`timescale 1ns/1ps
module gpio_wake_detect_bench;
    localparam int N  = 16;
    localparam int DW = 2 * N;

    logic          clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
    logic [N-1:0]  pins = '0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq, smi, sci;
    int vectors = 0, miscompares = 0;
    int tick_div = 1, tcnt = 0;
    logic [DW-1:0] r;

    gpio_wake_detect u_gpio_wake_detect (
        .clk(clk), .rst_n(rst_n), .slow_tick(tick), .pins_i(pins),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_o(irq), .smi_o(smi), .sci_o(sci)
    );

    always #2.5 clk = ~clk;

    // Slow tick: a one-clock pulse every tick_div clocks.
    always @(negedge clk) begin
        if (tcnt + 1 >= tick_div) begin tick <= 1'b1; tcnt <= 0; end
        else begin tick <= 1'b0; tcnt <= tcnt + 1; end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic pulse3(input int len, input int settle);
        pins[3] = 1'b1; cyc(len); pins[3] = 1'b0; cyc(settle);
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        cyc(4); rst_n = 1'b1; cyc(2);

        // R1: reset state of registers and outputs
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), r); chk("R1 register reset", r, '0);
        end
        chk("R1 outputs reset", DW'({irq, smi, sci}), '0);

        // R2: readback, upper-bit masking and unused offsets
        wr(4'd0, 32'hA5A5_1234); rd(4'd0, r); chk("R2 enable readback", r, 32'h0000_1234);
        wr(4'd3, 32'hDEAD_BEEF); rd(4'd3, r); chk("R2 debounce readback", r, 32'hDEAD_BEEF);
        wr(4'd6, 32'hFFFF_0F0F); rd(4'd6, r); chk("R2 smi mask readback", r, 32'h0000_0F0F);
        wr(4'd9, 32'h1234_5678); rd(4'd9, r); chk("R2 unused offset", r, '0);
        for (int a = 0; a < 8; a++) wr(4'(a), '0);
        wr(4'd4, 32'h0000_FFFF);

        // R3 R4 R5 R10: sweep every input through both polarities and both modes
        for (int i = 0; i < N; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int lv = 0; lv < 2; lv++) begin
                    pins = '1; pins[i] = pol[0];
                    wr(4'd0, DW'(1) << i);
                    wr(4'd1, DW'(pol) << i);
                    wr(4'd2, DW'(lv) << i);
                    cyc(8); wr(4'd4, 32'h0000_FFFF); cyc(3);
                    rd(4'd4, r); chk("R10 idle with other pins high", r, '0);
                    pins[i] = ~pol[0]; cyc(10);
                    rd(4'd4, r);
                    chk(pol ? "R4 active-low event" : "R3 active-high event", r, DW'(1) << i);
                    pins[i] = pol[0]; cyc(10);
                    rd(4'd4, r);
                    chk(lv ? "R5 level released" : "R3 edge sticky", r, lv ? '0 : DW'(1) << i);
                    wr(4'd4, 32'h0000_FFFF); cyc(2);
                    rd(4'd4, r); chk("R6 cleared", r, '0);
                end
            end
        end
        pins = '0; wr(4'd1, '0); wr(4'd2, '0);

        // R6: writing 0 leaves a sticky bit alone
        wr(4'd0, 32'h0000_0004); cyc(5); wr(4'd4, 32'h0000_FFFF);
        pins[2] = 1'b1; cyc(10); pins[2] = 1'b0; cyc(10);
        wr(4'd4, 32'h0000_0000); rd(4'd4, r); chk("R6 write 0 keeps", r, 32'h0000_0004);
        wr(4'd4, 32'h0000_0004); cyc(2); rd(4'd4, r); chk("R6 write 1 clears", r, '0);

        // R7: a disabled input neither shows nor routes
        wr(4'd0, '0); wr(4'd2, 32'h0000_FFFF); wr(4'd5, 32'h0000_FFFF);
        pins = 16'hFFFF; cyc(10);
        rd(4'd4, r); chk("R7 disabled status", r, '0);
        chk("R7 disabled irq", DW'(irq), '0);
        pins = '0; wr(4'd5, '0); wr(4'd2, '0); cyc(10);

        // R9: routing sweep over a fixed level pattern
        wr(4'd0, 32'h0000_FFFF); wr(4'd2, 32'h0000_FFFF);
        pins = 16'hA5C3; cyc(10);
        rd(4'd4, r); chk("R5 level pattern", r, 32'h0000_A5C3);
        for (int k = 0; k < N; k++) begin
            logic [N-1:0] m;
            m = 16'(1) << k;
            wr(4'd5, DW'(m)); wr(4'd6, DW'(~m)); wr(4'd7, DW'(16'(1) << (15 - k)));
            cyc(2);
            chk("R9 routed outputs", DW'({irq, smi, sci}),
                DW'({|(16'hA5C3 & m), |(16'hA5C3 & ~m), |(16'hA5C3 & (16'(1) << (15 - k)))}));
        end
        pins = '0; wr(4'd2, '0); wr(4'd5, '0); wr(4'd6, '0); wr(4'd7, '0);
        cyc(10); wr(4'd4, 32'h0000_FFFF);

        // R8: debounce thresholds on input 3 in edge mode, one tick per 4 clocks
        tick_div = 4;
        wr(4'd0, 32'h0000_0008);
        wr(4'd3, 32'h0000_0080); cyc(5); wr(4'd4, 32'h0000_FFFF);
        pulse3(12, 60);  rd(4'd4, r); chk("R8 code2 short pulse", r, '0);
        pulse3(80, 60);  rd(4'd4, r); chk("R8 code2 long pulse", r, 32'h0000_0008);
        wr(4'd4, 32'h0000_FFFF);
        wr(4'd3, 32'h0000_00C0); cyc(5);
        pulse3(100, 200); rd(4'd4, r); chk("R8 code3 short pulse", r, '0);
        pulse3(200, 200); rd(4'd4, r); chk("R8 code3 long pulse", r, 32'h0000_0008);
        wr(4'd4, 32'h0000_FFFF);
        wr(4'd3, 32'h0000_0040); cyc(5);
        pulse3(3, 30);   rd(4'd4, r); chk("R8 code1 short pulse", r, '0);
        pulse3(20, 30);  rd(4'd4, r); chk("R8 code1 long pulse", r, 32'h0000_0008);
        wr(4'd4, 32'h0000_FFFF);
        wr(4'd3, 32'h0000_0000); tick_div = 1000; cyc(5);
        pulse3(2, 10);   rd(4'd4, r); chk("R8 code0 immediate", r, 32'h0000_0008);

        report();
    end
endmodule